// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the integer execute unit of a small load/store processor pipeline. Each operation takes two data-width operands, a shift count and a four-bit operation code. It returns one data-width result and a flag that is set when that result is zero. The supported operations are wrapping add and subtract, three bitwise functions (AND, OR, NOR), signed and unsigned less-than tests that return 0 or 1, logical and arithmetic shifts, and placement of a half-word constant in the upper half of the word. The caller sign-extends or zero-extends any immediate before it reaches the block. A subtract by a constant is therefore issued as an add of a negative operand, and a bitwise inversion is issued as NOR against a zero operand. Branch logic uses the zero flag for its equal and not-equal tests.

The arithmetic is purely combinational. A thin registered stage around it captures the result and the zero flag on any cycle where the input valid is high, and presents them one cycle later together with an output valid. When the input valid is low, the captured values stay as they are.

Top module: `int_alu_top`

## Requirements
- R1: Code 0 returns opA + opB and code 1 returns opA - opB, both modulo 2^32. Overflow raises nothing.
- R2: Code 2 returns opA AND opB, code 3 returns opA OR opB and code 4 returns NOT(opA OR opB). Code 4 with opB = 0 returns the bitwise inverse of opA.
- R3: Code 5 returns 1 when opA < opB as two's-complement numbers and returns 0 otherwise.
- R4: Code 6 returns 1 when opA < opB as unsigned numbers and returns 0 otherwise. With opA = 0xFFFFFFFF and opB = 1, code 6 returns 0 and code 5 returns 1.
- R5: Code 7 shifts opA left and code 8 shifts opA right, both by shAmt (0 to 31) positions with zero fill. Code 9 shifts opA right with copies of bit 31 as the fill.
- R6: Code 10 returns opB[15:0] in bits 31:16 and zeros in bits 15:0.
- R7: zeroFlag is 1 exactly when the presented result is all zeros.
- R8: Codes 11 to 15 return a result of zero, whatever the operands are.
- R9: A cycle with validIn high makes validOut high on the next cycle, with that operation's result and flag. A cycle with validIn low makes validOut low on the next cycle, and result and zeroFlag keep their previous values.
- R10: While rst is high, and on the first cycle after it, validOut is 0, result is 0 and zeroFlag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Operation request this cycle |
| opSel | input | 4 | Operation code, 0 to 10 in use |
| opA | input | 32 | First operand, also the value that is shifted |
| opB | input | 32 | Second operand, also the source of the upper-half constant |
| shAmt | input | 5 | Shift count |
| validOut | output | 1 | Result below belongs to the previous cycle's request |
| result | output | 32 | Registered result |
| zeroFlag | output | 1 | Registered flag: result is zero |

## Verification
A fault in the decode or the datapath has no internal state to hide in. It corrupts the result captured on the same request, so it shows at the ports one cycle after the faulty request. The faults that escape easily sit at the ends of the ranges: the carry out of the adder when the signs differ, the top stage of the shifter, and the fill bit. For that reason, directed operands at 0, 1, all ones and the sign boundary run alongside seeded random traffic. A fault in the capture register shows up as a result that changes on a cycle when no request came in.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OpW = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9,
    OP_LUI  = 4'd10
  } aluOp_e;

  typedef enum logic [2:0] {
    RS_ARITH,
    RS_LOGIC,
    RS_CMP,
    RS_SHIFT,
    RS_UPPER,
    RS_NONE
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_NOR
  } logicOp_e;

  typedef struct packed {
    resSel_e  resSel;
    logic     invertB;
    logic     carryIn;
    logicOp_e logicOp;
    logic     cmpSigned;
    logic     shiftLeft;
    logic     shiftArith;
  } aluCtrl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [OpW-1:0] opSel,
  output aluCtrl_t       ctrl
);

  always_comb begin
    ctrl = '{resSel: RS_NONE, invertB: 1'b0, carryIn: 1'b0, logicOp: LG_AND,
             cmpSigned: 1'b0, shiftLeft: 1'b0, shiftArith: 1'b0};
    case (opSel)
      OP_ADD:  ctrl.resSel = RS_ARITH;
      OP_SUB: begin
        ctrl.resSel  = RS_ARITH;
        ctrl.invertB = 1'b1;
        ctrl.carryIn = 1'b1;
      end
      OP_AND: begin
        ctrl.resSel  = RS_LOGIC;
        ctrl.logicOp = LG_AND;
      end
      OP_OR: begin
        ctrl.resSel  = RS_LOGIC;
        ctrl.logicOp = LG_OR;
      end
      OP_NOR: begin
        ctrl.resSel  = RS_LOGIC;
        ctrl.logicOp = LG_NOR;
      end
      OP_SLT: begin
        ctrl.resSel    = RS_CMP;
        ctrl.invertB   = 1'b1;
        ctrl.carryIn   = 1'b1;
        ctrl.cmpSigned = 1'b1;
      end
      OP_SLTU: begin
        ctrl.resSel  = RS_CMP;
        ctrl.invertB = 1'b1;
        ctrl.carryIn = 1'b1;
      end
      OP_SLL: begin
        ctrl.resSel    = RS_SHIFT;
        ctrl.shiftLeft = 1'b1;
      end
      OP_SRL:  ctrl.resSel = RS_SHIFT;
      OP_SRA: begin
        ctrl.resSel     = RS_SHIFT;
        ctrl.shiftArith = 1'b1;
      end
      OP_LUI:  ctrl.resSel = RS_UPPER;
      default: ctrl.resSel = RS_NONE;
    endcase
  end

endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] valueIn,
  input  logic [SH_W-1:0]   shAmt,
  input  logic              shiftLeft,
  input  logic              shiftArith,
  output logic [DATA_W-1:0] valueOut
);

  logic              fillBit;
  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] stage [SH_W+1];

  // a left shift is a right shift of the bit-reversed word
  assign fillBit = shiftArith & ~shiftLeft & valueIn[DATA_W-1];

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign revIn[gi]  = valueIn[DATA_W-1-gi];
      assign revOut[gi] = stage[SH_W][DATA_W-1-gi];
    end
  endgenerate

  assign stage[0] = shiftLeft ? revIn : valueIn;

  genvar gs;
  generate
    for (gs = 0; gs < SH_W; gs++) begin : g_stage
      localparam int Step = 1 << gs;
      assign stage[gs+1] = shAmt[gs] ? {{Step{fillBit}}, stage[gs][DATA_W-1:Step]}
                                     : stage[gs];
    end
  endgenerate

  assign valueOut = shiftLeft ? revOut : stage[SH_W];

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shAmt,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] aluOut,
  output logic              aluZero
);

  localparam int Msb    = DATA_W - 1;
  localparam int UpperW = DATA_W / 2;

  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] bSide;
  logic              lessSigned;
  logic              lessUnsigned;
  logic [DATA_W-1:0] logicOut;
  logic [DATA_W-1:0] shiftOut;
  logic [DATA_W-1:0] upperOut;

  assign bSide   = opB ^ {DATA_W{ctrl.invertB}};
  assign sumFull = {1'b0, opA} + {1'b0, bSide} + {{DATA_W{1'b0}}, ctrl.carryIn};

  // signs differ: the negative operand is smaller; otherwise the difference sign decides
  assign lessSigned   = (opA[Msb] != opB[Msb]) ? opA[Msb] : sumFull[Msb];
  assign lessUnsigned = ~sumFull[DATA_W];

  always_comb begin
    case (ctrl.logicOp)
      LG_AND:  logicOut = opA & opB;
      LG_OR:   logicOut = opA | opB;
      LG_NOR:  logicOut = ~(opA | opB);
      default: logicOut = '0;
    endcase
  end

  int_alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shifter (
    .valueIn    (opA),
    .shAmt      (shAmt),
    .shiftLeft  (ctrl.shiftLeft),
    .shiftArith (ctrl.shiftArith),
    .valueOut   (shiftOut)
  );

  assign upperOut = {opB[UpperW-1:0], {(DATA_W-UpperW){1'b0}}};

  always_comb begin
    case (ctrl.resSel)
      RS_ARITH: aluOut = sumFull[DATA_W-1:0];
      RS_LOGIC: aluOut = logicOut;
      RS_CMP:   aluOut = {{(DATA_W-1){1'b0}}, ctrl.cmpSigned ? lessSigned : lessUnsigned};
      RS_SHIFT: aluOut = shiftOut;
      RS_UPPER: aluOut = upperOut;
      default:  aluOut = '0;
    endcase
  end

  assign aluZero = ~|aluOut;

endmodule

// File: rtl/int_alu_top.sv
module int_alu_top
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              validIn,
  input  logic [OpW-1:0]    opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shAmt,
  output logic              validOut,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag
);

  localparam int UpperW = DATA_W / 2;

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] aluOut;
  logic              aluZero;

  int_alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  int_alu_datapath #(.DATA_W(DATA_W), .SH_W(SH_W)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .shAmt   (shAmt),
    .ctrl    (ctrl),
    .aluOut  (aluOut),
    .aluZero (aluZero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      result   <= '0;
      zeroFlag <= 1'b1;
    end else begin
      validOut <= validIn;
      if (validIn) begin
        result   <= aluOut;
        zeroFlag <= aluZero;
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> (!validOut && $stable(result) && $stable(zeroFlag)));
  a_r7_flag_matches: assert property (@(posedge clk) disable iff (rst)
    zeroFlag == (result == '0));
  a_r3_cmp_single_bit: assert property (@(posedge clk) disable iff (rst)
    (validIn && (opSel == OP_SLT || opSel == OP_SLTU)) |=> (result[DATA_W-1:1] == '0));
  a_r6_upper_low_clear: assert property (@(posedge clk) disable iff (rst)
    (validIn && opSel == OP_LUI) |=> (result[UpperW-1:0] == '0));
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (validIn && opSel > OP_LUI) |=> (result == '0 && zeroFlag));

endmodule

// File: tb/sim_int_alu_top.sv
module sim_int_alu_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        validIn;
  logic [3:0]  opSel;
  logic [31:0] opA;
  logic [31:0] opB;
  logic [4:0]  shAmt;
  logic        validOut;
  logic [31:0] result;
  logic        zeroFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_top u0 (
    .clk(clk), .rst(rst), .validIn(validIn), .opSel(opSel), .opA(opA),
    .opB(opB), .shAmt(shAmt), .validOut(validOut), .result(result),
    .zeroFlag(zeroFlag)
  );

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh);
    case (op)
      4'd0:    return a + b;
      4'd1:    return a - b;
      4'd2:    return a & b;
      4'd3:    return a | b;
      4'd4:    return ~(a | b);
      4'd5:    return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd6:    return (a < b) ? 32'd1 : 32'd0;
      4'd7:    return a << sh;
      4'd8:    return a >> sh;
      4'd9:    return $unsigned($signed(a) >>> sh);
      4'd10:   return {b[15:0], 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:       return "R1";
      4'd2, 4'd3, 4'd4: return "R2";
      4'd5:             return "R3";
      4'd6:             return "R4";
      4'd7, 4'd8, 4'd9: return "R5";
      4'd10:            return "R6";
      default:          return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doOp(input logic [3:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [4:0] sh);
    logic [31:0] exp;
    exp = model(op, a, b, sh);
    @(negedge clk);
    validIn = 1'b1; opSel = op; opA = a; opB = b; shAmt = sh;
    @(negedge clk);
    validIn = 1'b0;
    check("R9 validOut", {31'd0, validOut}, 32'd1);
    check(tagOf(op), result, exp);
    check("R7 zeroFlag", {31'd0, zeroFlag}, {31'd0, exp == 32'd0});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240613));
    rst = 1'b1; validIn = 1'b0; opSel = '0; opA = '0; opB = '0; shAmt = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 validOut", {31'd0, validOut}, 32'd0);
    check("R10 result", result, 32'd0);
    check("R10 zeroFlag", {31'd0, zeroFlag}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after release", result, 32'd0);

    // R1 wrap and subtract
    doOp(4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);
    doOp(4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);
    doOp(4'd1, 32'd5, 32'd7, 5'd0);
    doOp(4'd1, 32'h1234_5678, 32'h1234_5678, 5'd0);
    doOp(4'd0, 32'd100, 32'hFFFF_FFEE, 5'd0);
    // R2 logic, NOR as inversion
    doOp(4'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0);
    doOp(4'd3, 32'hF000_0000, 32'h0000_000F, 5'd0);
    doOp(4'd4, 32'hA5A5_0F0F, 32'd0, 5'd0);
    doOp(4'd4, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0);
    // R3 / R4 compares
    doOp(4'd5, 32'hFFFF_FFFF, 32'd1, 5'd0);
    doOp(4'd6, 32'hFFFF_FFFF, 32'd1, 5'd0);
    doOp(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    doOp(4'd6, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    doOp(4'd5, 32'd42, 32'd42, 5'd0);
    doOp(4'd6, 32'd3, 32'd4, 5'd0);
    doOp(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    // R5 shifts at the count ends
    doOp(4'd7, 32'h8000_0001, 32'd0, 5'd0);
    doOp(4'd7, 32'h0000_0003, 32'd0, 5'd31);
    doOp(4'd8, 32'h8000_0000, 32'd0, 5'd31);
    doOp(4'd9, 32'h8000_0000, 32'd0, 5'd31);
    doOp(4'd9, 32'h4000_0000, 32'd0, 5'd30);
    doOp(4'd9, 32'hF00F_0000, 32'd0, 5'd8);
    doOp(4'd8, 32'hF00F_0000, 32'd0, 5'd8);
    // R6 upper placement
    doOp(4'd10, 32'hDEAD_BEEF, 32'hCAFE_1234, 5'd7);
    doOp(4'd10, 32'hFFFF_FFFF, 32'hFFFF_0000, 5'd0);
    // R8 unused codes
    for (int c = 11; c < 16; c++) doOp(4'(c), 32'hFFFF_FFFF, 32'h1234_5678, 5'd3);

    // R9 hold while idle: drive a new operation without validIn
    doOp(4'd3, 32'h0000_00F0, 32'h0000_0F00, 5'd0);
    held = result;
    @(negedge clk);
    validIn = 1'b0; opSel = 4'd0; opA = 32'd1; opB = 32'd1;
    @(negedge clk);
    check("R9 idle validOut", {31'd0, validOut}, 32'd0);
    check("R9 idle result", result, held);
    check("R9 idle zeroFlag", {31'd0, zeroFlag}, 32'd0);

    // random mix over all codes
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = {ra[31], 31'h7FFF_FFFF};
      doOp(4'($urandom_range(15, 0)), ra, rb, 5'($urandom_range(31, 0)));
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule